// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Carry and Zero Flags

This block is the arithmetic and logic datapath of a small accumulator-style controller. Each cycle it receives two byte operands and a five-bit operation code. From these it computes a byte result, a new carry value and a new zero value, and it also produces a write enable for each flag. The carry used by add-with-carry, subtract-with-borrow and the rotates comes from the block's own carry flag register. Two flag bits, carry (C) and zero (Z), are kept in registers inside the block. They change on a rising clock edge only when the operation-valid input is high and the matching write enable is set.

Each class of operation has its own rule for updating the flags. Arithmetic operations and shifts write both flags. Bitwise logic, complement, test and loads into the accumulator write only Z. A plain move writes neither flag. Three operations treat the flag register as a byte and apply AND, OR or XOR to it with the second operand.

The operation interface carries the valid strobe only and has no ready signal. The block never applies back-pressure and accepts an operation in every cycle. Result, next-flag and enable outputs are combinational from the inputs and the current carry, so the surrounding decoder can capture the result in the same cycle.

Top module: `byte_alu_flags`

## Requirements
- R1: ADD (code 0) gives result = a+b mod 256 and ADC (code 1) gives a+b+C mod 256. Both write C = carry out of bit 7 and Z = (result == 0).
- R2: SUB (code 2) gives a-b and SBB (code 3) gives a-b-C, both mod 256. Both write C = 1 exactly when unsigned a < b (+C for SBB), and Z = (result == 0).
- R3: AND (code 4), OR (code 5) and XOR (code 6) return the bitwise result and write only Z = (result == 0). c_write is 0 and the carry flag keeps its value.
- R4: CMP (code 7) returns operand a unchanged on result and writes C = (a < b unsigned) and Z = (a == b).
- R5: ASL (code 8) returns a shifted left with 0 into bit 0. ASR (code 9) returns a shifted right with bit 7 kept. Both write C = the bit shifted out and Z = (result == 0).
- R6: RLC (code 10) shifts left with the old C into bit 0 and RRC (code 11) shifts right with the old C into bit 7. Both write C = the bit shifted out and Z = (result == 0).
- R7: CPL (code 12) returns ~a and writes only Z = (result == 0).
- R8: INC (code 13) returns a+1 and DEC (code 14) returns a-1, both mod 256. INC writes C = (a == 0xFF), DEC writes C = (a == 0x00), and both write Z = (result == 0).
- R9: Flag-byte operations FAND (15), FOR (16) and FXOR (17) form a byte with C at bit 2, Z at bit 1 and zeros elsewhere, and combine it with b. Both flags take bits 2 and 1 of the combined value. The result is that value with every bit other than bits 2 and 1 cleared.
- R10: TST (code 18) returns a unchanged and writes only Z = ((a & b) == 0).
- R11: MOVA (code 19) returns b and writes only Z = (b == 0). MOVM (code 20) returns b and writes no flag.
- R12: A flag register takes its next value on a rising edge only when op_valid is 1 and its write enable is 1. Otherwise it holds.
- R13: A high rst at a rising edge clears both flags, and this takes priority over any operation.
- R14: Codes 21 to 31 give result 0 and set neither write enable, so the flags do not change even when op_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of both flags |
| op_valid | input | 1 | Operation strobe that allows the flag update |
| op_code | input | 5 | Operation select |
| opnd_a | input | 8 | First operand (accumulator side) |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Byte result of the operation |
| c_next | output | 1 | Carry value the operation produces |
| z_next | output | 1 | Zero value the operation produces |
| c_write | output | 1 | Operation writes the carry flag |
| z_write | output | 1 | Operation writes the zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The checker properties assume that op_valid, op_code and both operands have known values at every rising edge after reset. They also assume that rst is high at the first edge, so both flags start from a defined state. The bench meets these assumptions. It holds rst high from time zero for several cycles. It changes inputs only on falling edges. It drives each input to a defined value before it deasserts reset. Before every vector that depends on carry, it uses the flag-byte operations to put a known value into the carry flag.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned FC_POS = 2;   // carry bit inside the flag byte
  localparam int unsigned FZ_POS = 1;   // zero bit inside the flag byte

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_ADD  = 5'd0;
  localparam op_t OP_ADC  = 5'd1;
  localparam op_t OP_SUB  = 5'd2;
  localparam op_t OP_SBB  = 5'd3;
  localparam op_t OP_AND  = 5'd4;
  localparam op_t OP_OR   = 5'd5;
  localparam op_t OP_XOR  = 5'd6;
  localparam op_t OP_CMP  = 5'd7;
  localparam op_t OP_ASL  = 5'd8;
  localparam op_t OP_ASR  = 5'd9;
  localparam op_t OP_RLC  = 5'd10;
  localparam op_t OP_RRC  = 5'd11;
  localparam op_t OP_CPL  = 5'd12;
  localparam op_t OP_INC  = 5'd13;
  localparam op_t OP_DEC  = 5'd14;
  localparam op_t OP_FAND = 5'd15;
  localparam op_t OP_FOR  = 5'd16;
  localparam op_t OP_FXOR = 5'd17;
  localparam op_t OP_TST  = 5'd18;
  localparam op_t OP_MOVA = 5'd19;
  localparam op_t OP_MOVM = 5'd20;
  localparam op_t OP_LAST = OP_MOVM;

  typedef enum logic [1:0] {U_NONE, U_ARITH, U_SHIFT, U_LOGIC} unit_e;

  typedef struct packed {
    unit_e unit;
    logic  c_en;
    logic  z_en;
  } policy_t;

  // Which unit serves an operation and which flags it may write
  function automatic policy_t op_policy(input op_t op);
    policy_t p;
    p = '{unit: U_NONE, c_en: 1'b0, z_en: 1'b0};
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_INC, OP_DEC:
        p = '{unit: U_ARITH, c_en: 1'b1, z_en: 1'b1};
      OP_ASL, OP_ASR, OP_RLC, OP_RRC:
        p = '{unit: U_SHIFT, c_en: 1'b1, z_en: 1'b1};
      OP_AND, OP_OR, OP_XOR, OP_TST, OP_CPL, OP_MOVA:
        p = '{unit: U_LOGIC, c_en: 1'b0, z_en: 1'b1};
      OP_FAND, OP_FOR, OP_FXOR:
        p = '{unit: U_LOGIC, c_en: 1'b1, z_en: 1'b1};
      OP_MOVM:
        p = '{unit: U_LOGIC, c_en: 1'b0, z_en: 1'b0};
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/alu_arith_unit.sv
`timescale 1ns/1ps
module alu_arith_unit
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         z_out
);
  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  logic [W:0] ext_a;
  logic [W:0] ext_b;
  logic [W:0] ext_c;
  logic [W:0] acc;

  assign ext_a = {1'b0, a};
  assign ext_b = {1'b0, b};
  assign ext_c = {{W{1'b0}}, cin};

  // One W+1 bit adder/subtractor; the top bit is carry or borrow
  always_comb begin
    case (op)
      OP_ADD:         acc = ext_a + ext_b;
      OP_ADC:         acc = ext_a + ext_b + ext_c;
      OP_SUB, OP_CMP: acc = ext_a - ext_b;
      OP_SBB:         acc = ext_a - ext_b - ext_c;
      OP_INC:         acc = ext_a + ONE_X;
      OP_DEC:         acc = ext_a - ONE_X;
      default:        acc = '0;
    endcase
  end

  assign c_out = acc[W];
  assign z_out = (acc[W-1:0] == '0);
  assign res   = (op == OP_CMP) ? a : acc[W-1:0];
endmodule

// File: rtl/alu_shift_unit.sv
`timescale 1ns/1ps
module alu_shift_unit
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         z_out
);
  always_comb begin
    case (op)
      OP_ASL: begin
        res   = {a[W-2:0], 1'b0};
        c_out = a[W-1];
      end
      OP_ASR: begin
        res   = {a[W-1], a[W-1:1]};
        c_out = a[0];
      end
      OP_RLC: begin
        res   = {a[W-2:0], cin};
        c_out = a[W-1];
      end
      OP_RRC: begin
        res   = {cin, a[W-1:1]};
        c_out = a[0];
      end
      default: begin
        res   = a;
        c_out = 1'b0;
      end
    endcase
  end

  assign z_out = (res == '0);
endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  op_t          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         fc,
  input  logic         fz,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         z_out
);
  localparam logic [W-1:0] FMASK = W'((1 << FC_POS) | (1 << FZ_POS));

  logic [W-1:0] fbyte;
  logic [W-1:0] fnew;
  logic [W-1:0] masked;

  always_comb begin
    fbyte         = '0;
    fbyte[FC_POS] = fc;
    fbyte[FZ_POS] = fz;
  end

  always_comb begin
    case (op)
      OP_FAND: fnew = fbyte & b;
      OP_FOR:  fnew = fbyte | b;
      OP_FXOR: fnew = fbyte ^ b;
      default: fnew = fbyte;
    endcase
  end

  assign masked = a & b;

  always_comb begin
    c_out = 1'b0;
    case (op)
      OP_AND: begin
        res   = masked;
        z_out = (masked == '0);
      end
      OP_OR: begin
        res   = a | b;
        z_out = ((a | b) == '0);
      end
      OP_XOR: begin
        res   = a ^ b;
        z_out = ((a ^ b) == '0);
      end
      OP_TST: begin
        res   = a;
        z_out = (masked == '0);
      end
      OP_CPL: begin
        res   = ~a;
        z_out = (a == '1);
      end
      OP_MOVA, OP_MOVM: begin
        res   = b;
        z_out = (b == '0);
      end
      OP_FAND, OP_FOR, OP_FXOR: begin
        res   = fnew & FMASK;
        c_out = fnew[FC_POS];
        z_out = fnew[FZ_POS];
      end
      default: begin
        res   = '0;
        z_out = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_bank.sv
`timescale 1ns/1ps
module alu_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)        bit_q <= 1'b0;
      else if (en[i]) bit_q <= d[i];
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/byte_alu_flags.sv
`timescale 1ns/1ps
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  output logic [W-1:0]    result,
  output logic            c_next,
  output logic            z_next,
  output logic            c_write,
  output logic            z_write,
  output logic            flag_c,
  output logic            flag_z
);
  localparam int unsigned NFLAG = 2;

  policy_t    pol;
  logic [W-1:0] ar_res, sh_res, lg_res;
  logic       ar_c, ar_z, sh_c, sh_z, lg_c, lg_z;
  logic [NFLAG-1:0] f_en, f_d, f_q;

  assign pol = op_policy(op_code);

  alu_arith_unit #(.W(W)) u_arith (
    .op(op_code), .a(opnd_a), .b(opnd_b), .cin(flag_c),
    .res(ar_res), .c_out(ar_c), .z_out(ar_z)
  );

  alu_shift_unit #(.W(W)) u_shift (
    .op(op_code), .a(opnd_a), .cin(flag_c),
    .res(sh_res), .c_out(sh_c), .z_out(sh_z)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op(op_code), .a(opnd_a), .b(opnd_b), .fc(flag_c), .fz(flag_z),
    .res(lg_res), .c_out(lg_c), .z_out(lg_z)
  );

  always_comb begin
    case (pol.unit)
      U_ARITH: begin result = ar_res; c_next = ar_c; z_next = ar_z; end
      U_SHIFT: begin result = sh_res; c_next = sh_c; z_next = sh_z; end
      U_LOGIC: begin result = lg_res; c_next = lg_c; z_next = lg_z; end
      default: begin result = '0;     c_next = 1'b0; z_next = 1'b0; end
    endcase
  end

  assign c_write = pol.c_en;
  assign z_write = pol.z_en;

  assign f_en = {c_write, z_write} & {NFLAG{op_valid}};
  assign f_d  = {c_next, z_next};

  alu_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .en(f_en), .d(f_d), .q(f_q)
  );

  assign flag_c = f_q[1];
  assign flag_z = f_q[0];
endmodule

// File: rtl/byte_alu_flags_chk.sv
`timescale 1ns/1ps
module byte_alu_flags_chk
  import byte_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [OP_W-1:0] op_code,
  input logic [W-1:0]    opnd_a,
  input logic [W-1:0]    opnd_b,
  input logic [W-1:0]    result,
  input logic            c_next,
  input logic            z_next,
  input logic            c_write,
  input logic            z_write,
  input logic            flag_c,
  input logic            flag_z
);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(flag_c) && $stable(flag_z)));

  p_carry_load_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && c_write) |=> (flag_c == $past(c_next)));

  p_zero_load_r12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && z_write) |=> (flag_z == $past(z_next)));

  p_logic_keeps_c_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
      |=> $stable(flag_c));

  p_cmp_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_CMP) |-> (result == opnd_a && c_next == (opnd_a < opnd_b)
                             && z_next == (opnd_a == opnd_b)));

  p_inc_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_INC) |-> (c_write && z_write && c_next == (opnd_a == '1)));

  p_move_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_MOVM) |-> (!c_write && !z_write && result == opnd_b));

  p_reset_clear_r13: assert property (@(posedge clk)
    rst |=> (!flag_c && !flag_z));

  p_unused_quiet_r14: assert property (@(posedge clk) disable iff (rst)
    (op_code > OP_LAST) |-> (!c_write && !z_write));
endmodule

bind byte_alu_flags byte_alu_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
  .c_next(c_next), .z_next(z_next), .c_write(c_write), .z_write(z_write),
  .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/byte_alu_flags_tb.sv
`timescale 1ns/1ps
module byte_alu_flags_tb;
  import byte_alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic [7:0] result;
  logic       c_next, z_next, c_write, z_write, flag_c, flag_z;

  int  nchk  = 0;
  int  nfail = 0;
  bit  done  = 1'b0;
  bit  mc = 1'b0;
  bit  mz = 1'b0;

  always #2.5 clk = ~clk;

  byte_alu_flags u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .c_next(c_next), .z_next(z_next), .c_write(c_write), .z_write(z_write),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  // {op[33:29], a[28:21], b[20:13], cin[12], res[11:4], cw, cv, zw, zv}
  localparam int NV = 28;
  localparam logic [33:0] VEC [NV] = '{
    {5'd0,  8'h3C, 8'hC4, 1'b0, 8'h00, 4'b1111},
    {5'd1,  8'h7F, 8'h00, 1'b1, 8'h80, 4'b1010},
    {5'd1,  8'hFF, 8'hFF, 1'b1, 8'hFF, 4'b1110},
    {5'd2,  8'h10, 8'h20, 1'b0, 8'hF0, 4'b1110},
    {5'd2,  8'h55, 8'h55, 1'b0, 8'h00, 4'b1011},
    {5'd3,  8'h20, 8'h1F, 1'b1, 8'h00, 4'b1011},
    {5'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 4'b1110},
    {5'd4,  8'hF0, 8'h0F, 1'b1, 8'h00, 4'b0011},
    {5'd5,  8'hA0, 8'h05, 1'b0, 8'hA5, 4'b0010},
    {5'd6,  8'h5A, 8'h5A, 1'b1, 8'h00, 4'b0011},
    {5'd7,  8'h12, 8'h34, 1'b0, 8'h12, 4'b1110},
    {5'd7,  8'h34, 8'h34, 1'b1, 8'h34, 4'b1011},
    {5'd8,  8'h81, 8'h00, 1'b1, 8'h02, 4'b1110},
    {5'd9,  8'h81, 8'h00, 1'b0, 8'hC0, 4'b1110},
    {5'd10, 8'h80, 8'h00, 1'b0, 8'h00, 4'b1111},
    {5'd11, 8'h02, 8'h00, 1'b1, 8'h81, 4'b1010},
    {5'd12, 8'hFF, 8'h00, 1'b1, 8'h00, 4'b0011},
    {5'd13, 8'hFF, 8'h00, 1'b0, 8'h00, 4'b1111},
    {5'd14, 8'h00, 8'h00, 1'b0, 8'hFF, 4'b1110},
    {5'd14, 8'h01, 8'h00, 1'b1, 8'h00, 4'b1011},
    {5'd18, 8'hF0, 8'h0F, 1'b1, 8'hF0, 4'b0011},
    {5'd19, 8'h11, 8'h00, 1'b0, 8'h00, 4'b0011},
    {5'd20, 8'h11, 8'h9C, 1'b1, 8'h9C, 4'b0000},
    {5'd25, 8'h11, 8'h22, 1'b1, 8'h00, 4'b0000},
    {5'd13, 8'h7F, 8'h00, 1'b1, 8'h80, 4'b1010},
    {5'd10, 8'h7F, 8'h00, 1'b1, 8'hFF, 4'b1010},
    {5'd9,  8'h7E, 8'h00, 1'b1, 8'h3F, 4'b1010},
    {5'd18, 8'h0F, 8'h01, 1'b0, 8'h0F, 4'b0010}
  };

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:         return "R1";
      5'd2, 5'd3:         return "R2";
      5'd4, 5'd5, 5'd6:   return "R3";
      5'd7:               return "R4";
      5'd8, 5'd9:         return "R5";
      5'd10, 5'd11:       return "R6";
      5'd12:              return "R7";
      5'd13, 5'd14:       return "R8";
      5'd15, 5'd16, 5'd17: return "R9";
      5'd18:              return "R10";
      5'd19, 5'd20:       return "R11";
      default:            return "R14";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one operation with op_valid high across one rising edge
  task automatic run_op(input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b);
    @(negedge clk);
    op_code  = op;
    opnd_a   = a;
    opnd_b   = b;
    op_valid = 1'b1;
    #1;
  endtask

  task automatic end_op();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Put a known carry in place without touching Z
  task automatic set_carry(input bit v);
    run_op(v ? OP_FOR : OP_FAND, 8'h00, v ? 8'h04 : 8'hFB);
    end_op();
    mc = v;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R12: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "carry after reset", {7'b0, flag_c}, 8'h00);
    chk("R13", "zero after reset",  {7'b0, flag_z}, 8'h00);
    rst = 1'b0;

    // Table walk: every op class with its flag policy
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string       r;
      v = VEC[i];
      r = req_of(v[33:29]);
      set_carry(v[12]);
      run_op(v[33:29], v[28:21], v[20:13]);
      chk(r, "result", result, v[11:4]);
      chk(r, "c_write", {7'b0, c_write}, {7'b0, v[3]});
      chk(r, "z_write", {7'b0, z_write}, {7'b0, v[1]});
      if (v[3]) chk(r, "c_next", {7'b0, c_next}, {7'b0, v[2]});
      if (v[1]) chk(r, "z_next", {7'b0, z_next}, {7'b0, v[0]});
      end_op();
      if (v[3]) mc = v[2];
      if (v[1]) mz = v[0];
      chk(r, "flag_c held/loaded (R12)", {7'b0, flag_c}, {7'b0, mc});
      chk(r, "flag_z held/loaded (R12)", {7'b0, flag_z}, {7'b0, mz});
    end

    // R9: flag byte operations
    run_op(OP_FOR, 8'h00, 8'h06);
    chk("R9", "FOR result", result, 8'h06);
    end_op();
    chk("R9", "FOR flags", {6'b0, flag_c, flag_z}, 8'h03);
    run_op(OP_FAND, 8'h00, 8'h04);
    chk("R9", "FAND result", result, 8'h04);
    end_op();
    chk("R9", "FAND flags", {6'b0, flag_c, flag_z}, 8'h02);
    run_op(OP_FXOR, 8'h00, 8'hFF);
    chk("R9", "FXOR result masked", result, 8'h02);
    end_op();
    chk("R9", "FXOR flags", {6'b0, flag_c, flag_z}, 8'h01);

    // R12: op_valid low leaves flags alone
    @(negedge clk);
    op_code = OP_ADD; opnd_a = 8'hFF; opnd_b = 8'h01; op_valid = 1'b0;
    @(negedge clk);
    chk("R12", "flags with op_valid low", {6'b0, flag_c, flag_z}, 8'h01);

    // R14: unused code with op_valid high
    run_op(5'd31, 8'h00, 8'h00);
    chk("R14", "unused result", result, 8'h00);
    end_op();
    chk("R14", "flags after unused code", {6'b0, flag_c, flag_z}, 8'h01);

    // R13: reset beats a valid flag-setting operation
    run_op(OP_FOR, 8'h00, 8'h06);
    end_op();
    chk("R9", "flags set before reset", {6'b0, flag_c, flag_z}, 8'h03);
    @(negedge clk);
    rst = 1'b1; op_code = OP_FOR; opnd_b = 8'h06; op_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; op_valid = 1'b0;
    chk("R13", "flags after mid-run reset", {6'b0, flag_c, flag_z}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule